// File: doc/BRIEF.md
# Fault-Aware Workload Dispatcher

This block hands already-scheduled tasks, one at a time, to one of `NUM_PE` processing elements. A task is an identifier plus its execution time in cycles. Every element keeps the dispatcher informed through its own status lines: how many tasks wait in its buffer, and the sum of their execution times. The dispatcher holds each task in a single output stage. It offers the task to exactly one element and keeps offering it until that element takes it.

Three selection policies are available. The balanced policy sends the task to the live element with the smallest combined workload. The next-neighbour policy steps through the live elements in index order. The random policy draws an element from a 16-bit LFSR and draws again whenever it lands on a dead one.

A fault pulse marks an element dead for good. From then on that element is never chosen. The failed element streams the tasks it still holds back through a return channel. Those tasks land in a reclaim FIFO, which is served ahead of new input. A task that is waiting in the output stage for the failed element is redirected in the same cycle. When no element is left alive, an error flag rises.

Top module: `wl_dispatch`

## Requirements
- R1: After reset `out_valid` is all zero, `no_target` is 0, and both `in_ready` and `ret_ready` are 1.
- R2: With `sel_policy` 2'b00 (2'b11 behaves the same), a task goes to the live element with the smallest key, where key = count × 2^16 + execution sum, compared unsigned. On equal keys the lowest index wins. `st_count` and `st_sum` pack element i at bits [i*CNT_W +: CNT_W] and [i*SUM_W +: SUM_W].
- R3: With `sel_policy` 2'b01, a task goes to the first live element after the previous next-neighbour target, wrapping around and ignoring status. The first such dispatch after reset goes to element 0.
- R4: With `sel_policy` 2'b10, every target is a live element. Over 64 tasks with all elements alive, every element is reached.
- R5: `out_valid` is one-hot and bit i addresses element i. It holds steady with `out_task_id` and `out_exec` equal to the task until `out_ready[i]` is high at a clock edge. With no further work pending, it then drops to zero.
- R6: After a `fault_valid` pulse naming element i, element i is never offered a task again. When every element is dead, `no_target` is 1, `in_ready` is 0 and `out_valid` is zero.
- R7: Returned tasks are offered in arrival order and before any new input. `in_ready` stays low while the reclaim FIFO holds an entry.
- R8: If the element targeted by the held task fails before it accepts the task, then in the cycle after the fault the same task is offered to a live element chosen by the policy.
- R9: A fault that arrives in the same cycle as a selection excludes the failing element from that selection.
- R10: `ret_ready` is low while the reclaim FIFO holds `RCL_DEPTH` tasks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_policy | input | 2 | 00 balanced, 01 next-neighbour, 10 random, 11 balanced |
| in_valid | input | 1 | New scheduled task present |
| in_ready | output | 1 | New task accepted at this edge |
| in_task_id | input | ID_W | New task identifier |
| in_exec | input | EXEC_W | New task execution cycles |
| out_valid | output | NUM_PE | One-hot task offer per element |
| out_ready | input | NUM_PE | Per-element acceptance |
| out_task_id | output | ID_W | Offered task identifier |
| out_exec | output | EXEC_W | Offered task execution cycles |
| st_count | input | NUM_PE*CNT_W | Per-element buffered task count |
| st_sum | input | NUM_PE*SUM_W | Per-element summed execution cycles |
| fault_valid | input | 1 | Permanent failure pulse |
| fault_pe | input | IDX_W | Index of the failing element |
| ret_valid | input | 1 | Returned task present |
| ret_ready | output | 1 | Reclaim FIFO has room |
| ret_task_id | input | ID_W | Returned task identifier |
| ret_exec | input | EXEC_W | Returned task execution cycles |
| no_target | output | 1 | No live element remains |

## Verification
A failure and a target selection can land in the same cycle in two ways. The first is a fault pulse raised in the very cycle a new task enters an empty stage, while status makes the failing element the lightest. The second is a fault naming the element that the held task is currently offered to. The bench provokes the first by driving `in_valid` and `fault_valid` at the same falling edge. It then judges the offer at the next falling edge against the lightest surviving element, computed from the status it drives. For the second, the bench leaves `out_ready` low, pulses the fault, and expects the same task identifier offered to the next-lightest live element one cycle later.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    POL_BALANCE = 2'b00,
    POL_NEXT    = 2'b01,
    POL_RANDOM  = 2'b10,
    POL_SPARE   = 2'b11
  } disp_policy_e;

  localparam int unsigned PRNG_W    = 16;
  localparam logic [15:0] PRNG_SEED = 16'hACE1;
  localparam logic [15:0] PRNG_TAPS = 16'hB400;
endpackage

// File: rtl/disp_fifo.sv
module disp_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_en,
  output logic [W-1:0] rd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             push, pop;

  assign wr_ready = (count_q != CNT_W'(DEPTH));
  assign rd_valid = (count_q != '0);
  assign rd_data  = mem[rd_ptr_q];
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_en && rd_valid;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    count_d = count_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (push || pop) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_data;
  end

  // R10: occupancy never exceeds the storage
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/disp_lightest.sv
module disp_lightest #(
  parameter int NUM_PE = 4,
  parameter int CNT_W  = 6,
  parameter int SUM_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_PE-1:0]       live,
  input  logic [NUM_PE*CNT_W-1:0] cnt_flat,
  input  logic [NUM_PE*SUM_W-1:0] sum_flat,
  output logic                    found,
  output logic [IDX_W-1:0]        idx
);
  localparam int KEY_W = CNT_W + SUM_W;

  logic [KEY_W-1:0] key_arr [NUM_PE];

  genvar g;
  generate
    for (g = 0; g < NUM_PE; g++) begin : g_key
      assign key_arr[g] = {cnt_flat[g*CNT_W +: CNT_W], sum_flat[g*SUM_W +: SUM_W]};
    end
  endgenerate

  always_comb begin
    logic [KEY_W-1:0] best;
    logic [IDX_W-1:0] ii;
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NUM_PE; i++) begin
      ii = IDX_W'(i);
      if (live[ii] && (!found || key_arr[ii] < best)) begin
        found = 1'b1;
        best  = key_arr[ii];
        idx   = ii;
      end
    end
  end
endmodule

// File: rtl/disp_next_live.sv
module disp_next_live #(
  parameter int NUM_PE = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_PE-1:0] live,
  input  logic [IDX_W-1:0]  last,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    int c;
    logic [IDX_W-1:0] ci;
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= NUM_PE; k++) begin
      c  = (int'(last) + k) % NUM_PE;
      ci = c[IDX_W-1:0];
      if (!found && live[ci]) begin
        found = 1'b1;
        idx   = ci;
      end
    end
  end
endmodule

// File: rtl/disp_prng_pick.sv
module disp_prng_pick
  import disp_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [NUM_PE-1:0] live,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  logic [PRNG_W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = {1'b0, lfsr_q[PRNG_W-1:1]} ^ (lfsr_q[0] ? PRNG_TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr_q <= PRNG_SEED;
    else if (step) lfsr_q <= lfsr_d;
  end

  assign idx   = IDX_W'(lfsr_q % PRNG_W'(NUM_PE));
  assign found = live[idx];
endmodule

// File: rtl/wl_dispatch.sv
module wl_dispatch
  import disp_pkg::*;
#(
  parameter int NUM_PE    = 4,
  parameter int ID_W      = 8,
  parameter int EXEC_W    = 16,
  parameter int CNT_W     = 6,
  parameter int SUM_W     = 16,
  parameter int RCL_DEPTH = 8,
  localparam int IDX_W    = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              sel_policy,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ID_W-1:0]         in_task_id,
  input  logic [EXEC_W-1:0]       in_exec,
  output logic [NUM_PE-1:0]       out_valid,
  input  logic [NUM_PE-1:0]       out_ready,
  output logic [ID_W-1:0]         out_task_id,
  output logic [EXEC_W-1:0]       out_exec,
  input  logic [NUM_PE*CNT_W-1:0] st_count,
  input  logic [NUM_PE*SUM_W-1:0] st_sum,
  input  logic                    fault_valid,
  input  logic [IDX_W-1:0]        fault_pe,
  input  logic                    ret_valid,
  output logic                    ret_ready,
  input  logic [ID_W-1:0]         ret_task_id,
  input  logic [EXEC_W-1:0]       ret_exec,
  output logic                    no_target
);
  localparam int TASK_W = ID_W + EXEC_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  disp_policy_e pol;
  assign pol = disp_policy_e'(sel_policy);

  // state
  logic [NUM_PE-1:0] alive_q, alive_d;
  logic              stg_vld_q, stg_vld_d, stg_pend_q, stg_pend_d;
  logic [IDX_W-1:0]  stg_tgt_q, stg_tgt_d, rr_last_q;
  logic [ID_W-1:0]   stg_id_q, stg_id_d;
  logic [EXEC_W-1:0] stg_exec_q, stg_exec_d;

  // fault view used for every selection in this cycle
  logic [NUM_PE-1:0] fault_mask, live_eff;
  assign fault_mask = fault_valid ? (NUM_PE'(1) << fault_pe) : '0;
  assign live_eff   = alive_q & ~fault_mask;

  // reclaim FIFO
  logic              rcl_rd_valid, rcl_rd_en;
  logic [TASK_W-1:0] rcl_rd_data;

  disp_fifo #(.W(TASK_W), .DEPTH(RCL_DEPTH)) u_reclaim (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_valid (ret_valid),
    .wr_ready (ret_ready),
    .wr_data  ({ret_task_id, ret_exec}),
    .rd_valid (rcl_rd_valid),
    .rd_en    (rcl_rd_en),
    .rd_data  (rcl_rd_data)
  );

  // candidate selectors
  logic             lt_found, nx_found, rn_found, rn_step;
  logic [IDX_W-1:0] lt_idx, nx_idx, rn_idx;

  disp_lightest #(.NUM_PE(NUM_PE), .CNT_W(CNT_W), .SUM_W(SUM_W), .IDX_W(IDX_W)) u_lightest (
    .live     (live_eff),
    .cnt_flat (st_count),
    .sum_flat (st_sum),
    .found    (lt_found),
    .idx      (lt_idx)
  );

  disp_next_live #(.NUM_PE(NUM_PE), .IDX_W(IDX_W)) u_next (
    .live  (live_eff),
    .last  (rr_last_q),
    .found (nx_found),
    .idx   (nx_idx)
  );

  disp_prng_pick #(.NUM_PE(NUM_PE), .IDX_W(IDX_W)) u_prng (
    .clk   (clk),
    .rst_n (rst_ni),
    .step  (rn_step),
    .live  (live_eff),
    .found (rn_found),
    .idx   (rn_idx)
  );

  logic             sel_ok;
  logic [IDX_W-1:0] sel_idx;
  always_comb begin
    case (pol)
      POL_NEXT:   begin sel_ok = nx_found; sel_idx = nx_idx; end
      POL_RANDOM: begin sel_ok = rn_found; sel_idx = rn_idx; end
      default:    begin sel_ok = lt_found; sel_idx = lt_idx; end
    endcase
  end

  // stage control
  logic accept, tgt_hit, need_tgt, stage_free, src_avail, load, sel_take;
  assign accept     = stg_vld_q && out_ready[stg_tgt_q];
  assign tgt_hit    = stg_vld_q && fault_mask[stg_tgt_q] && !accept;
  assign need_tgt   = stg_pend_q || tgt_hit;
  assign stage_free = (!stg_vld_q && !stg_pend_q) || accept;
  assign src_avail  = rcl_rd_valid || in_valid;
  assign load       = stage_free && src_avail && sel_ok;
  assign sel_take   = load || (need_tgt && sel_ok);
  assign rcl_rd_en  = load && rcl_rd_valid;
  assign in_ready   = stage_free && !rcl_rd_valid && sel_ok;
  assign rn_step    = (pol == POL_RANDOM) && ((stage_free && src_avail) || need_tgt);

  always_comb begin
    alive_d    = alive_q & ~fault_mask;
    stg_vld_d  = stg_vld_q;
    stg_pend_d = stg_pend_q;
    stg_tgt_d  = stg_tgt_q;
    stg_id_d   = stg_id_q;
    stg_exec_d = stg_exec_q;
    if (load) begin
      stg_vld_d  = 1'b1;
      stg_pend_d = 1'b0;
      stg_tgt_d  = sel_idx;
      if (rcl_rd_valid) {stg_id_d, stg_exec_d} = rcl_rd_data;
      else              {stg_id_d, stg_exec_d} = {in_task_id, in_exec};
    end else if (need_tgt) begin
      stg_vld_d  = sel_ok;
      stg_pend_d = !sel_ok;
      stg_tgt_d  = sel_ok ? sel_idx : stg_tgt_q;
    end else if (accept) begin
      stg_vld_d  = 1'b0;
    end
  end

  logic alive_en, stg_en, rr_en;
  assign alive_en = fault_valid;
  assign stg_en   = load || need_tgt || accept;
  assign rr_en    = (pol == POL_NEXT) && sel_take;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      alive_q    <= '1;
      stg_vld_q  <= 1'b0;
      stg_pend_q <= 1'b0;
      stg_tgt_q  <= '0;
      rr_last_q  <= IDX_W'(NUM_PE - 1);
    end else begin
      if (alive_en) alive_q <= alive_d;
      if (stg_en) begin
        stg_vld_q  <= stg_vld_d;
        stg_pend_q <= stg_pend_d;
        stg_tgt_q  <= stg_tgt_d;
      end
      if (rr_en) rr_last_q <= sel_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_id_q   <= '0;
      stg_exec_q <= '0;
    end else if (load) begin
      stg_id_q   <= stg_id_d;
      stg_exec_q <= stg_exec_d;
    end
  end

  assign out_valid   = stg_vld_q ? (NUM_PE'(1) << stg_tgt_q) : '0;
  assign out_task_id = stg_id_q;
  assign out_exec    = stg_exec_q;
  assign no_target   = ~|alive_q;

  // R5: an unaccepted offer stays put unless its target fails
  assert_hold_offer_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (stg_vld_q && !accept && !tgt_hit) |=>
      ($stable(out_valid) && $stable(out_task_id) && $stable(out_exec)));

  // R6: only live elements are offered tasks
  assert_live_target_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid & ~alive_q) == '0);

  // R6: a dead element never comes back
  assert_dead_stays_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (alive_q & ~$past(alive_q)) == '0);

  // R6: nothing moves when no element is left
  assert_no_target_idle_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    no_target |-> (out_valid == '0 && !in_ready));

  // R8: a failed target's task is kept and re-offered
  assert_retarget_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (tgt_hit && (|live_eff) && pol != POL_RANDOM) |=>
      (out_valid != '0 && $stable(out_task_id) && $stable(out_exec)));
endmodule

// File: tb/tb_wl_dispatch.sv
`timescale 1ns/1ps
module tb_wl_dispatch;
  localparam int N  = 4;
  localparam int CW = 6;
  localparam int SW = 16;

  logic          clk, rst_n;
  logic [1:0]    sel_policy;
  logic          in_valid, in_ready;
  logic [7:0]    in_task_id;
  logic [15:0]   in_exec;
  logic [N-1:0]  out_valid, out_ready;
  logic [7:0]    out_task_id;
  logic [15:0]   out_exec;
  logic [N*CW-1:0] st_count;
  logic [N*SW-1:0] st_sum;
  logic          fault_valid;
  logic [1:0]    fault_pe;
  logic          ret_valid, ret_ready;
  logic [7:0]    ret_task_id;
  logic [15:0]   ret_exec;
  logic          no_target;

  wl_dispatch dut (
    .clk(clk), .rst_n(rst_n), .sel_policy(sel_policy),
    .in_valid(in_valid), .in_ready(in_ready), .in_task_id(in_task_id), .in_exec(in_exec),
    .out_valid(out_valid), .out_ready(out_ready), .out_task_id(out_task_id), .out_exec(out_exec),
    .st_count(st_count), .st_sum(st_sum),
    .fault_valid(fault_valid), .fault_pe(fault_pe),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_task_id(ret_task_id), .ret_exec(ret_exec),
    .no_target(no_target)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cnt_b [N];
  int sum_b [N];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_status();
    for (int i = 0; i < N; i++) begin
      st_count[i*CW +: CW] = CW'(cnt_b[i]);
      st_sum[i*SW +: SW]   = SW'(sum_b[i]);
    end
  endtask

  function automatic int lightest(input logic [N-1:0] live);
    longint best = -1;
    int pick = -1;
    for (int i = 0; i < N; i++) begin
      longint k = longint'(cnt_b[i]) * 65536 + longint'(sum_b[i]);
      if (live[i] && (pick < 0 || k < best)) begin
        best = k;
        pick = i;
      end
    end
    return pick;
  endfunction

  task automatic push_in(input logic [7:0] id, input logic [15:0] ex);
    @(negedge clk);
    in_valid = 1'b1; in_task_id = id; in_exec = ex;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push_ret(input logic [7:0] id, input logic [15:0] ex);
    @(negedge clk);
    ret_valid = 1'b1; ret_task_id = id; ret_exec = ex;
    #2;
    while (!ret_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic get_out(output int idx, output int id, output int ex);
    @(negedge clk); #1;
    while (out_valid == '0) begin @(negedge clk); #1; end
    chk("R5 one-hot offer", $countones(out_valid), 1);
    idx = 0;
    for (int i = 0; i < N; i++) if (out_valid[i]) idx = i;
    id = int'(out_task_id);
    ex = int'(out_exec);
    out_ready = N'(1) << idx;
    @(negedge clk);
    out_ready = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx, id, ex, exp;
    logic [N-1:0] hit;
    logic [N-1:0] live;
    rst_n = 1'b0; sel_policy = 2'b00; in_valid = 1'b0; in_task_id = '0; in_exec = '0;
    out_ready = '0; fault_valid = 1'b0; fault_pe = '0; ret_valid = 1'b0;
    ret_task_id = '0; ret_exec = '0;
    for (int i = 0; i < N; i++) begin cnt_b[i] = 0; sum_b[i] = 0; end
    apply_status();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 no_target", int'(no_target), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 ret_ready", int'(ret_ready), 1);

    // R5: hold while not accepted
    cnt_b = '{1, 1, 0, 1}; sum_b = '{0, 0, 0, 0}; apply_status();
    push_in(8'h11, 16'd33);
    #1;
    chk("R5 offer target", int'(out_valid), 4);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk("R5 held offer", int'(out_valid), 4);
      chk("R5 held id", int'(out_task_id), 'h11);
      chk("R5 held exec", int'(out_exec), 33);
    end
    get_out(idx, id, ex);
    #1;
    chk("R5 cleared after accept", int'(out_valid), 0);

    // R2: count dominates the sum; equal keys go low
    cnt_b = '{1, 0, 1, 1}; sum_b = '{0, 65535, 0, 0}; apply_status();
    push_in(8'h12, 16'd1); get_out(idx, id, ex);
    chk("R2 count dominates", idx, 1);
    cnt_b = '{2, 2, 2, 2}; sum_b = '{9, 4, 4, 8}; apply_status();
    push_in(8'h13, 16'd2); get_out(idx, id, ex);
    chk("R2 tie to lowest", idx, 1);

    // R2: sweep of status patterns
    for (int t = 0; t < 24; t++) begin
      for (int i = 0; i < N; i++) begin
        cnt_b[i] = (t + 3 * i) % 4;
        sum_b[i] = ((5 * t + 7 * i) % 3) * 1000 + ((t >> 2) & 1) * i * 10;
      end
      apply_status();
      exp = lightest(4'hF);
      push_in(8'(t + 32), 16'(t * 3));
      get_out(idx, id, ex);
      chk("R2 lightest target", idx, exp);
      chk("R2 task id", id, t + 32);
      chk("R2 task exec", ex, t * 3);
    end

    // R3: next-neighbour ignores status
    sel_policy = 2'b01;
    cnt_b = '{3, 3, 3, 0}; sum_b = '{0, 0, 0, 0}; apply_status();
    for (int t = 0; t < 6; t++) begin
      push_in(8'(t + 64), 16'd4); get_out(idx, id, ex);
      chk("R3 neighbour order", idx, t % 4);
    end

    // R4: random covers live elements
    sel_policy = 2'b10;
    hit = '0;
    for (int t = 0; t < 64; t++) begin
      push_in(8'(t + 96), 16'd5); get_out(idx, id, ex);
      chk("R4 random task id", id, t + 96);
      hit = hit | (N'(1) << idx);
    end
    chk("R4 all reached", int'(hit), 15);

    // R8: held target fails before accepting
    sel_policy = 2'b00;
    cnt_b = '{2, 2, 0, 2}; sum_b = '{0, 0, 0, 0}; apply_status();
    push_in(8'h31, 16'd5);
    #1;
    chk("R8 initial target", int'(out_valid), 4);
    fault_valid = 1'b1; fault_pe = 2'd2;
    @(negedge clk);
    fault_valid = 1'b0;
    #1;
    chk("R8 retarget", int'(out_valid), 1);
    chk("R8 same task", int'(out_task_id), 'h31);
    get_out(idx, id, ex);
    chk("R8 delivered id", id, 'h31);

    // R6: dead element never chosen though lightest
    cnt_b = '{3, 1, 0, 2}; sum_b = '{0, 0, 0, 0}; apply_status();
    for (int t = 0; t < 3; t++) begin
      push_in(8'(t + 200), 16'd6); get_out(idx, id, ex);
      chk("R6 dead skipped", idx, 1);
    end

    // R7: reclaim before new input, in order
    cnt_b = '{0, 1, 0, 1}; apply_status();
    push_ret(8'hA0, 16'd1); push_ret(8'hA1, 16'd2); push_ret(8'hA2, 16'd3);
    @(negedge clk);
    in_valid = 1'b1; in_task_id = 8'h55; in_exec = 16'd9;
    #2;
    chk("R7 input blocked", int'(in_ready), 0);
    fork
      push_in(8'h55, 16'd9);
      begin
        get_out(idx, id, ex); chk("R7 order 0", id, 'hA0);
        get_out(idx, id, ex); chk("R7 order 1", id, 'hA1);
        chk("R7 exec of return", ex, 2);
        get_out(idx, id, ex); chk("R7 order 2", id, 'hA2);
        get_out(idx, id, ex); chk("R7 input last", id, 'h55);
      end
    join

    // R10: reclaim FIFO fills up
    for (int t = 0; t < 9; t++) push_ret(8'(t + 176), 16'(t));
    @(negedge clk); #1;
    chk("R10 ret_ready low when full", int'(ret_ready), 0);
    for (int t = 0; t < 9; t++) begin
      get_out(idx, id, ex);
      chk("R7 drain order", id, t + 176);
    end

    // R9: fault in the selection cycle
    cnt_b = '{0, 2, 0, 1}; sum_b = '{0, 0, 0, 0}; apply_status();
    @(negedge clk);
    in_valid = 1'b1; in_task_id = 8'h77; in_exec = 16'd7;
    fault_valid = 1'b1; fault_pe = 2'd0;
    @(negedge clk);
    in_valid = 1'b0; fault_valid = 1'b0;
    #1;
    live = 4'b1010;
    chk("R9 failing element excluded", int'(out_valid), 1 << lightest(live));
    chk("R9 task id", int'(out_task_id), 'h77);
    get_out(idx, id, ex);

    // R3: neighbour order skips dead elements
    sel_policy = 2'b01;
    for (int t = 0; t < 4; t++) begin
      push_in(8'(t + 240), 16'd8); get_out(idx, id, ex);
      chk("R3 skip dead", idx, (t % 2 == 0) ? 3 : 1);
    end

    // R6: nothing left alive
    @(negedge clk); fault_valid = 1'b1; fault_pe = 2'd1;
    @(negedge clk); fault_pe = 2'd3;
    @(negedge clk); fault_valid = 1'b0; in_valid = 1'b1; in_task_id = 8'h99;
    #2;
    chk("R6 no_target", int'(no_target), 1);
    chk("R6 in_ready low", int'(in_ready), 0);
    @(negedge clk); #1;
    chk("R6 no offer", int'(out_valid), 0);
    in_valid = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule